// File: doc/BRIEF.md
# Headphone DC Offset Series Correction Sequencer

This block runs, in the background, the digital side of a DC-offset trim loop for a pair of headphone outputs (left and right). Software writes a trigger bit for a channel. The block then applies a series of single-LSB steps to that channel's signed correction word. Before each step it waits a settle interval, then samples a one-bit offset-sign input that the analog measurement path provides. The length of the series comes from a 7-bit programmable count. Low values of that count are reserved and give the minimum series length.

A trigger can arrive at any moment. Trigger bits act for a single cycle and are then forgotten, but each channel latches its request until that channel's series has run. Only one channel runs at a time. When both are waiting, left goes first, and a running series is never interrupted. Reading the trigger location returns one busy flag per channel, so software can poll for completion.

The block has no data stream at its edge. The register interface is a plain single-cycle write strobe plus a combinational read port, so there is no back-pressure to manage. The correction words are level outputs that the analog trim path reads continuously.

Top module: `dcs_series_seq`

## Requirements
- R1: After reset the count location (address 0) reads 16, the trigger location (address 1) reads 0, and both correction outputs are 0.
- R2: A write to address 0 stores wr_data[6:0] as the series count, which reads back unchanged. A count N in 16..127 makes a triggered channel take exactly N steps.
- R3: A stored count in the reserved range 0..15 reads back as written but makes a series of exactly 16 steps.
- R4: A write to address 1 treats bit 0 as the left trigger and bit 1 as the right trigger. A 1 requests a series on that channel, and a 0 requests nothing and leaves the outputs untouched. The written value is acted on in that one cycle only.
- R5: Reading address 1 returns {6'b0, busy_right, busy_left}. A channel's busy bit is 1 from the cycle after its trigger is accepted until its last step, and 0 afterwards.
- R6: At most one channel is stepped at any time. When both are pending, left runs first. A channel's whole series completes before the other channel's correction moves.
- R7: Each step changes the running channel's correction by exactly one LSB. The step is +1 when offs_sign is 1 and −1 when it is 0, sampled at the end of each settle interval of SETTLE_CYC cycles.
- R8: Corrections saturate at +127 and −128 and never wrap.
- R9: A trigger for a channel that is already busy is ignored, and its series length does not grow. A trigger for an idle channel that arrives while the other channel runs is held and served afterwards.
- R10: The count is captured when a channel's series starts. Writing the count during a series affects only later series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 count, 1 triggers |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 count, 1 busy flags |
| rd_data | output | 8 | Combinational read data |
| offs_sign | input | 1 | Measured offset sign: 1 steps up, 0 steps down |
| corr_l | output | 8 | Left signed correction word |
| corr_r | output | 8 | Right signed correction word |

## Verification
The main function is tried with three kinds of sign input. A constant high or low sign shows whether the step count and direction are right. A sign taken from a model that compares the left correction with a target shows that the sign is sampled on every step rather than once per series, because the final value depends on the oscillation around the target. Simultaneous and overlapping triggers show the left-first order, the held request and the ignored retrigger. Counts of 5, 16, 20, 30 and 127, together with long runs into both rails, show the reserved-range mapping, the count capture and saturation.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int NCH        = 2;   // left = 0, right = 1
  localparam int CNT_W      = 7;
  localparam int MIN_SERIES = 16;
  localparam int REG_W      = 8;
  localparam int CORR_W     = 8;

  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_TRIG  = 1'b1;

  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int N        = NCH,
  parameter int CW       = CNT_W,
  parameter int DW       = REG_W,
  parameter int RST_CNT  = MIN_SERIES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [N-1:0]  done_vec,
  output logic [CW-1:0] series_cnt,
  output logic [N-1:0]  pend
);
  localparam int PAD_C = DW - CW;
  localparam int PAD_T = DW - N;

  logic [N-1:0] trig_pulse;
  logic [N-1:0] pend_nxt;

  // trigger bits live only for the write cycle
  assign trig_pulse = (wr_en && wr_addr == ADDR_TRIG) ? wr_data[N-1:0] : '0;
  // a busy channel ignores further triggers; done clears the request
  assign pend_nxt   = (pend & ~done_vec) | (trig_pulse & ~pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      series_cnt <= CW'(RST_CNT);
      pend       <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_COUNT)
        series_cnt <= wr_data[CW-1:0];
      pend <= pend_nxt;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_COUNT) rd_data = {{PAD_C{1'b0}}, series_cnt};
    else                       rd_data = {{PAD_T{1'b0}}, pend};
  end
endmodule

// File: rtl/dcs_settle_timer.sv
module dcs_settle_timer #(
  parameter int SETTLE_CYC = 27_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic tick
);
  localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TW-1:0] TOP = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] cnt;
  logic          armed;

  assign tick = armed && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= TOP;
      armed <= 1'b1;
    end else if (tick) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dcs_corr_acc.sv
module dcs_corr_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         up,
  output logic [W-1:0] corr
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic at_max, at_min;
  assign at_max = (corr == MAX_V);
  assign at_min = (corr == MIN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr <= '0;
    end else if (step_en) begin
      if (up && !at_max)       corr <= corr + 1'b1;
      else if (!up && !at_min) corr <= corr - 1'b1;
    end
  end
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
  import dcs_pkg::*;
#(
  parameter int N    = NCH,
  parameter int CW   = CNT_W,
  parameter int MINS = MIN_SERIES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic [CW-1:0] series_cnt,
  input  logic          tick,
  output logic          tmr_load,
  output logic [N-1:0]  step_vec,
  output logic [N-1:0]  done_vec
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  seq_state_t    state;
  logic [IW-1:0] cur;
  logic [CW-1:0] remain;
  logic [IW-1:0] pick;
  logic [CW-1:0] eff_cnt;
  logic          start, last;

  // lowest index wins: left before right
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) pick = IW'(i);
  end

  assign eff_cnt  = (series_cnt < CW'(MINS)) ? CW'(MINS) : series_cnt;
  assign start    = (state == SQ_IDLE) && (|pend);
  assign last     = (remain == CW'(1));
  assign tmr_load = start || (state == SQ_RUN && tick && !last);

  always_comb begin
    step_vec = '0;
    done_vec = '0;
    if (state == SQ_RUN && tick) begin
      step_vec[cur] = 1'b1;
      done_vec[cur] = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cur    <= '0;
      remain <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          cur    <= pick;
          remain <= eff_cnt;
          state  <= SQ_RUN;
        end
        SQ_RUN: if (tick) begin
          remain <= remain - 1'b1;
          if (last) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_series_seq.sv
module dcs_series_seq
  import dcs_pkg::*;
#(
  parameter int SETTLE_CYC = 27_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              offs_sign,
  output logic [CORR_W-1:0] corr_l,
  output logic [CORR_W-1:0] corr_r
);
  logic [CNT_W-1:0]          series_cnt;
  logic [NCH-1:0]            pend, done_vec, step_vec;
  logic                      tmr_load, tick;
  logic [NCH-1:0][CORR_W-1:0] corr;

  dcs_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .done_vec(done_vec), .series_cnt(series_cnt), .pend(pend)
  );

  dcs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .series_cnt(series_cnt), .tick(tick),
    .tmr_load(tmr_load), .step_vec(step_vec), .done_vec(done_vec)
  );

  dcs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dcs_corr_acc #(.W(CORR_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .step_en(step_vec[g]), .up(offs_sign), .corr(corr[g])
    );
  end

  assign corr_l = corr[0];
  assign corr_r = corr[1];
endmodule

// File: rtl/dcs_series_chk.sv
module dcs_series_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] corr_l,
  input logic [7:0] corr_r,
  input logic [1:0] pend
);
  logic       seen;
  logic [7:0] prev_l, prev_r;
  logic [1:0] prev_pend;
  logic signed [8:0] dl, dr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_l    <= '0;
      prev_r    <= '0;
      prev_pend <= '0;
    end else begin
      seen      <= 1'b1;
      prev_l    <= corr_l;
      prev_r    <= corr_r;
      prev_pend <= pend;
    end
  end

  assign dl = $signed({corr_l[7], corr_l}) - $signed({prev_l[7], prev_l});
  assign dr = $signed({corr_r[7], corr_r}) - $signed({prev_r[7], prev_r});

  a_r7_one_lsb_l: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dl <= 9'sd1 && dl >= -9'sd1));
  a_r7_one_lsb_r: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dr <= 9'sd1 && dr >= -9'sd1));
  a_r6_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !((corr_l != prev_l) && (corr_r != prev_r)));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !((prev_l == 8'h7f && corr_l == 8'h80) || (prev_l == 8'h80 && corr_l == 8'h7f)
            || (prev_r == 8'h7f && corr_r == 8'h80) || (prev_r == 8'h80 && corr_r == 8'h7f)));
  a_r5_trig_sets_busy_l: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[0]) |=> pend[0]);
  a_r5_trig_sets_busy_r: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[1]) |=> pend[1]);
  a_r5_step_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((corr_l == prev_l || prev_pend[0]) && (corr_r == prev_r || prev_pend[1])));
endmodule

bind dcs_series_seq dcs_series_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .corr_l(corr_l), .corr_r(corr_r), .pend(pend)
);

// File: tb/sim_dcs_series_seq.sv
`timescale 1ns/1ps
module sim_dcs_series_seq;
  localparam int SETTLE = 3;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] corr_l, corr_r;
  logic       offs_sign;
  logic       sign_fix = 1'b1;
  logic       track_en = 1'b0;
  int         track_tgt = 0;
  int         n_chk = 0, n_fail = 0;

  always #(HALF) clk = ~clk;

  // analog model: either fixed sign or comparator against a target
  assign offs_sign = track_en ? (int'($signed(corr_l)) < track_tgt) : sign_fix;

  dcs_series_seq #(.SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .offs_sign(offs_sign), .corr_l(corr_l), .corr_r(corr_r)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  function automatic int cl();
    return int'($signed(corr_l));
  endfunction
  function automatic int cr();
    return int'($signed(corr_r));
  endfunction

  task automatic wait_mask(int mask, int want);
    int v;
    for (int i = 0; i < 20000; i++) begin
      rd(1'b1, v);
      if ((v & mask) == want) return;
      @(negedge clk);
    end
    chk("wait busy", v & mask, want);
  endtask

  task automatic t_reset();
    int v;
    rd(1'b0, v); chk("R1 count reset", v, 16);
    rd(1'b1, v); chk("R1 busy reset", v, 0);
    chk("R1 corr_l reset", cl(), 0);
    chk("R1 corr_r reset", cr(), 0);
  endtask

  task automatic t_left_up();
    int v;
    sign_fix = 1'b1;
    wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R5 left busy after trigger", v, 1);
    wait_mask(3, 0);
    chk("R2 R7 left 16 steps up", cl(), 16);
    chk("R6 right untouched", cr(), 0);
  endtask

  task automatic t_right_down();
    int v;
    sign_fix = 1'b0;
    wr(1'b0, 8'd20);
    rd(1'b0, v); chk("R2 count readback", v, 20);
    wr(1'b1, 8'h02);
    wait_mask(3, 0);
    chk("R2 R7 right 20 steps down", cr(), -20);
    chk("R6 left untouched", cl(), 16);
  endtask

  task automatic t_zero_trigger();
    int v;
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R4 zero write no busy", v, 0);
    repeat (SETTLE * 4) @(negedge clk);
    chk("R4 zero write corr_l", cl(), 16);
    chk("R4 zero write corr_r", cr(), -20);
  endtask

  task automatic t_reserved();
    int v;
    sign_fix = 1'b0;
    wr(1'b0, 8'd5);
    rd(1'b0, v); chk("R3 reserved readback", v, 5);
    wr(1'b1, 8'h01);
    wait_mask(3, 0);
    chk("R3 reserved gives 16 steps", cl(), 0);
  endtask

  task automatic t_order();
    int v;
    sign_fix = 1'b1;
    wr(1'b0, 8'd16);
    wr(1'b1, 8'h03);
    rd(1'b1, v); chk("R5 both busy", v, 3);
    wait_mask(1, 0);
    chk("R6 left done first", cl(), 16);
    chk("R6 right not started", cr(), -20);
    wait_mask(3, 0);
    chk("R6 right after left", cr(), -4);
  endtask

  task automatic t_latch_count();
    sign_fix = 1'b1;
    wr(1'b1, 8'h01);
    wr(1'b0, 8'd30);
    wait_mask(3, 0);
    chk("R10 count captured at start", cl(), 32);
    sign_fix = 1'b0;
    wr(1'b1, 8'h01);
    wait_mask(3, 0);
    chk("R10 new count used next", cl(), 2);
  endtask

  task automatic t_retrigger();
    int v;
    sign_fix = 1'b1;
    wr(1'b0, 8'd16);
    wr(1'b1, 8'h01);
    repeat (SETTLE * 3) @(negedge clk);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R9 right held while left runs", v, 3);
    wait_mask(3, 0);
    chk("R9 retrigger ignored", cl(), 18);
    chk("R9 held right served", cr(), 12);
  endtask

  task automatic t_saturate();
    sign_fix = 1'b1;
    wr(1'b0, 8'd127);
    wr(1'b1, 8'h03);
    wait_mask(3, 0);
    chk("R8 left top rail", cl(), 127);
    chk("R8 right top rail", cr(), 127);
    sign_fix = 1'b0;
    wr(1'b1, 8'h02);
    wait_mask(3, 0);
    chk("R2 127 steps", cr(), 0);
    wr(1'b1, 8'h02);
    wait_mask(3, 0);
    wr(1'b1, 8'h02);
    wait_mask(3, 0);
    chk("R8 right bottom rail", cr(), -128);
  endtask

  task automatic t_track();
    wr(1'b0, 8'd16);
    track_tgt = 120;
    track_en  = 1'b1;
    wr(1'b1, 8'h01);
    wait_mask(3, 0);
    track_en = 1'b0;
    chk("R7 sign sampled each step", cl(), 119);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left_up();
    t_right_down();
    t_zero_trigger();
    t_reserved();
    t_order();
    t_latch_count();
    t_retrigger();
    t_saturate();
    t_track();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule